// File: doc/BRIEF.md
# Serial Canonic Signed-Digit Converter

This block takes a W-bit two's complement word and rewrites it as a string of W signed digits, each -1, 0 or +1. The recoding keeps the numeric value and uses as few nonzero digits as possible. No two neighbouring digits are both nonzero. It suits constant-coefficient multipliers, where every nonzero digit costs one adder or subtractor.

Conversion is serial. One digit position is resolved per clock, starting at the least significant position. A carry-like flag runs from each position to the next. The source word enters through a valid/ready handshake. The finished digit vector leaves through a second valid/ready handshake, and its valid flag doubles as the done indication.

Back-pressure rules:
- The block accepts a word only while `in_ready` is high. `in_ready` is high only when the block is idle.
- Once `out_valid` rises, the result is held unchanged until the consumer raises `out_ready`.
- The cycle after the output handshake, the block is idle again and `in_ready` returns high.

Top module: `csd_serial_conv`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `out_digits` is all zeros.
- R2: A word is captured on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` then stays 0 until the result is taken. `in_valid` and `in_word` have no effect while the block is busy or holding a result.
- R3: Digit i sits at bits [2i+1:2i] of `out_digits`. The codes are 2'b00 for zero, 2'b01 for +1 and 2'b11 for -1. The code 2'b10 never appears while `out_valid` is 1.
- R4: While `out_valid` is 1, the sum over i of digit_i·2^i equals the captured word read as a signed integer.
- R5: While `out_valid` is 1, no two adjacent digits are both nonzero.
- R6: `out_valid` rises exactly W clock edges after the edge that captured the word.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_digits` does not change. After the edge with `out_valid` and `out_ready` both 1, `out_valid` is 0 and `in_ready` is 1.
- R8: The digit vector is the unique minimal form. It equals the nonadjacent form of the signed input, including the extremes -2^(W-1) and 2^(W-1)-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Source word offered |
| in_ready | output | 1 | Block idle and able to take a word |
| in_word | input | W | Two's complement source word |
| out_valid | output | 1 | Digit vector complete (done) |
| out_ready | input | 1 | Consumer takes the digit vector |
| out_digits | output | 2W | Signed digits, two bits each, digit 0 lowest |

## Verification
Every cycle, the assertions check that the digit codes are legal, that the digit sum matches the word captured at the input handshake, and that no adjacent pair is nonzero. They also check that the result stays stable under back-pressure, that the two ready/valid sides are never active together, and that the latency is W edges.

Only the bench scenarios can show the reset values and the exact digit pattern of the unique minimal form for every 8-bit input. The same goes for input offers that are ignored while busy and for a result held through a long stall.

// File: rtl/csd_pkg.sv
package csd_pkg;
  typedef logic [1:0] csd_code_t;

  localparam csd_code_t CSD_ZERO = 2'b00;
  localparam csd_code_t CSD_POS  = 2'b01;
  localparam csd_code_t CSD_NEG  = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_HOLD = 2'b10
  } conv_state_e;

  function automatic csd_code_t csd_encode(input logic nonzero, input logic negative);
    if (!nonzero)     return CSD_ZERO;
    else if (negative) return CSD_NEG;
    else               return CSD_POS;
  endfunction
endpackage

// File: rtl/csd_digit_cell.sv
module csd_digit_cell
  import csd_pkg::*;
(
  input  logic      bit_cur,
  input  logic      bit_prev,
  input  logic      bit_next,
  input  logic      flag_in,
  output logic      flag_out,
  output csd_code_t code
);
  logic edge_seen;

  always_comb begin
    edge_seen = bit_cur ^ bit_prev;
    flag_out  = edge_seen & ~flag_in;
    code      = csd_encode(flag_out, bit_next);
  end
endmodule

// File: rtl/csd_seq_ctrl.sv
module csd_seq_ctrl
  import csd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic load,
  output logic step,
  output logic out_valid
);
  localparam int IW = (W > 1) ? $clog2(W) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(W - 1);

  conv_state_e   state_q;
  logic [IW-1:0] idx_q;

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_HOLD);
  assign load      = in_ready & in_valid;
  assign step      = (state_q == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (in_valid) begin
          state_q <= ST_RUN;
          idx_q   <= '0;
        end
        ST_RUN: begin
          if (idx_q == LAST_IDX) state_q <= ST_HOLD;
          else                   idx_q   <= idx_q + 1'b1;
        end
        ST_HOLD: if (out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/csd_digit_store.sv
module csd_digit_store
  import csd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   word,
  input  csd_code_t      code,
  input  logic           flag_new,
  output logic           bit_cur,
  output logic           bit_prev,
  output logic           bit_next,
  output logic           flag_q,
  output logic [2*W-1:0] digits
);
  localparam int EW = W + 1;

  logic [EW-1:0]  ext_q;
  logic           prev_q;
  logic [2*W-1:0] dig_q;

  assign bit_cur  = ext_q[0];
  assign bit_next = ext_q[1];
  assign bit_prev = prev_q;
  assign digits   = dig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q  <= '0;
      prev_q <= 1'b0;
      flag_q <= 1'b0;
      dig_q  <= '0;
    end else if (load) begin
      ext_q  <= {word[W-1], word};
      prev_q <= 1'b0;
      flag_q <= 1'b0;
      dig_q  <= '0;
    end else if (step) begin
      ext_q  <= {ext_q[EW-1], ext_q[EW-1:1]};
      prev_q <= ext_q[0];
      flag_q <= flag_new;
      dig_q  <= {code, dig_q[2*W-1:2]};
    end
  end
endmodule

// File: rtl/csd_serial_conv.sv
module csd_serial_conv
  import csd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   in_word,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [2*W-1:0] out_digits
);
  logic      load, step;
  logic      bit_cur, bit_prev, bit_next, flag_q, flag_new;
  csd_code_t code;

  csd_seq_ctrl #(.W(W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .load(load), .step(step), .out_valid(out_valid)
  );

  csd_digit_cell cell_i (
    .bit_cur(bit_cur), .bit_prev(bit_prev), .bit_next(bit_next),
    .flag_in(flag_q), .flag_out(flag_new), .code(code)
  );

  csd_digit_store #(.W(W)) store_i (
    .clk(clk), .rst_n(rst_n), .load(load), .step(step), .word(in_word),
    .code(code), .flag_new(flag_new), .bit_cur(bit_cur), .bit_prev(bit_prev),
    .bit_next(bit_next), .flag_q(flag_q), .digits(out_digits)
  );
endmodule

// File: rtl/csd_serial_conv_chk.sv
module csd_serial_conv_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic [W-1:0]   in_word,
  input logic           out_valid,
  input logic           out_ready,
  input logic [2*W-1:0] out_digits
);
  int   cap_val;
  int   lat_cnt;

  function automatic int digit_sum(input logic [2*W-1:0] d);
    int s = 0;
    for (int i = 0; i < W; i++) begin
      if (d[2*i +: 2] == 2'b01) s += (1 << i);
      else if (d[2*i +: 2] == 2'b11) s -= (1 << i);
    end
    return s;
  endfunction

  function automatic logic has_bad_code(input logic [2*W-1:0] d);
    logic bad = 1'b0;
    for (int i = 0; i < W; i++) if (d[2*i +: 2] == 2'b10) bad = 1'b1;
    return bad;
  endfunction

  function automatic logic has_adjacent(input logic [2*W-1:0] d);
    logic adj = 1'b0;
    for (int i = 0; i < W - 1; i++)
      if (d[2*i] && d[2*i+2]) adj = 1'b1;
    return adj;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_val <= 0;
      lat_cnt <= 0;
    end else if (in_valid && in_ready) begin
      cap_val <= int'($signed(in_word));
      lat_cnt <= 0;
    end else if (!in_ready && !out_valid) begin
      lat_cnt <= lat_cnt + 1;
    end
  end

  // R3
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !has_bad_code(out_digits));

  // R4
  value_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (digit_sum(out_digits) == cap_val));

  // R5
  no_adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !has_adjacent(out_digits));

  // R6
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_cnt == W));

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_digits)));

  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready));

  // R2
  sides_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
endmodule

bind csd_serial_conv csd_serial_conv_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
  .out_digits(out_digits)
);

// File: tb/csd_serial_conv_tb_top.sv
module csd_serial_conv_tb_top;
  localparam int W = 8;
  localparam int NV = 8;
  localparam logic [W+2*W-1:0] VEC [NV] = '{
    {8'h00, 16'h0000}, {8'h01, 16'h0001}, {8'h03, 16'h0013}, {8'hFF, 16'h0003},
    {8'h80, 16'hC000}, {8'h7F, 16'h4003}, {8'h55, 16'h1111}, {8'hAA, 16'hC444}
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [W-1:0]   in_word = '0;
  logic           out_valid;
  logic           out_ready = 1'b0;
  logic [2*W-1:0] out_digits;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  csd_serial_conv #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_digits(out_digits)
  );

  task automatic check(input string req, input logic ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] ref_naf(input int x);
    logic [2*W-1:0] r = '0;
    int v = x;
    for (int i = 0; i < W; i++) begin
      if (v % 2 != 0) begin
        if ((v & 3) == 1) begin r[2*i +: 2] = 2'b01; v = v - 1; end
        else begin r[2*i +: 2] = 2'b11; v = v + 1; end
      end
      v = v / 2;
    end
    return r;
  endfunction

  function automatic int sum_of(input logic [2*W-1:0] d);
    int s = 0;
    for (int i = 0; i < W; i++) begin
      if (d[2*i +: 2] == 2'b01) s += (1 << i);
      else if (d[2*i +: 2] == 2'b11) s -= (1 << i);
    end
    return s;
  endfunction

  function automatic logic adj_ok(input logic [2*W-1:0] d);
    logic ok = 1'b1;
    for (int i = 0; i < W - 1; i++) if (d[2*i] && d[2*i+2]) ok = 1'b0;
    return ok;
  endfunction

  // Offer a word, wait for the result, return digits and latency; leaves result held.
  task automatic convert(input logic [W-1:0] w, input bit keep_offering,
                         output logic [2*W-1:0] d, output int lat);
    @(negedge clk);
    in_word = w; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (keep_offering) in_word = ~w; else in_valid = 1'b0;
    lat = 0;
    while (!out_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    in_valid = 1'b0;
    d = out_digits;
  endtask

  task automatic take;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2*W-1:0] d;
    int lat;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 in_ready", in_ready == 1'b1, in_ready, 1);
    check("R1 out_valid", out_valid == 1'b0, out_valid, 0);
    check("R1 out_digits", out_digits == '0, out_digits, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table of vectors: R3 R8
    for (int k = 0; k < NV; k++) begin
      convert(VEC[k][3*W-1:2*W], 1'b0, d, lat);
      check("R8 table digits", d == VEC[k][2*W-1:0], d, VEC[k][2*W-1:0]);
      check("R6 latency", lat == W, lat, W);
      take();
    end

    // exhaustive sweep: R3 R4 R5 R8
    for (int v = 0; v < (1 << W); v++) begin
      int sv;
      sv = int'($signed(W'(v)));
      convert(W'(v), 1'b0, d, lat);
      check("R8 naf", d == ref_naf(sv), d, ref_naf(sv));
      check("R4 value", sum_of(d) == sv, sum_of(d), sv);
      check("R5 adjacency", adj_ok(d), d, 0);
      for (int i = 0; i < W; i++)
        check("R3 code", d[2*i +: 2] != 2'b10, d[2*i +: 2], 0);
      take();
    end

    // R2: offers during conversion and hold are ignored
    convert(8'h2D, 1'b1, d, lat);
    check("R2 busy ignores input", d == ref_naf(45), d, ref_naf(45));
    check("R2 in_ready low while holding", in_ready == 1'b0, in_ready, 0);
    // R7: stall then release
    in_valid = 1'b1; in_word = 8'h11;
    repeat (5) @(negedge clk);
    in_valid = 1'b0;
    check("R7 held valid", out_valid == 1'b1, out_valid, 1);
    check("R7 held digits", out_digits == d, out_digits, d);
    check("R2 hold ignores input", out_digits == ref_naf(45), out_digits, ref_naf(45));
    take();
    check("R7 valid dropped", out_valid == 1'b0, out_valid, 0);
    check("R7 ready back", in_ready == 1'b1, in_ready, 1);

    // reset in the middle of a conversion returns to the R1 state
    @(negedge clk);
    in_word = 8'h9C; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset ready", in_ready == 1'b1, in_ready, 1);
    check("R1 mid-run reset valid", out_valid == 1'b0, out_valid, 0);
    check("R1 mid-run reset digits", out_digits == '0, out_digits, 0);
    rst_n = 1'b1;
    @(negedge clk);
    convert(8'h9C, 1'b0, d, lat);
    check("R8 after reset", d == ref_naf(-100), d, ref_naf(-100));
    take();

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule